// File: doc/BRIEF.md
# Segment field deinterleaver

This block sits at the write-back end of a vector segment load. Each incoming beat carries one loaded element together with its element number and its field number inside the segment. The block works out which vector register and which byte lanes that element belongs to, applies the active-length and mask rules, and issues a single byte-enabled register-file write. Field f of every segment goes to its own register group. That group starts at the destination base plus f times the register-group size, so a segment of NF fields is spread across NF consecutive groups.

The vector register width is 128 bits. The configuration inputs are the destination base register, the field count, the element-width code, the group-size code, the active length, the mask with its enable, and two policy bits. They are expected to stay constant while the beats of one instruction flow. Beats may arrive in any order and with idle cycles between them. Each accepted beat produces its write on the next clock edge.

Top module: `seg_deint`

## Requirements
- R1: After reset, `wr_valid` is low and `wr_reg`, `wr_be` and `wr_data` are all zero.
- R2: A beat accepted at a rising edge (`in_valid` high) produces at most one write, visible with `wr_valid` high after that same edge. A cycle with `in_valid` low produces no write, and `wr_be` is zero whenever `wr_valid` is low.
- R3: The field count is `nf_m1`+1, and the group size in registers is 1 << `emul_code` (codes 0..3 give 1, 2, 4, 8). Field f is written to the group whose first register is `vd` + f × group size. For example, three fields with a group size of 2 and base 4 use registers 4–5, 6–7 and 8–9.
- R4: The element width in bytes is 1 << `eew_code` (codes 0..3 give 8, 16, 32 and 64 bits). One register holds 16 / width elements. Element i is written to register group-base + i / (16/width), starting at byte lane (i mod (16/width)) × width. `wr_be` has exactly those width bytes set. Those bytes of `wr_data` hold the low bytes of `in_data`, in order, and every other byte is zero.
- R5: The same element index, active length and mask bit decide the outcome in every field group, and elements of different fields share their in-register position.
- R6: An element with index ≥ `vl` is a tail element. With `tail_agn` low it produces no write. With `tail_agn` high its bytes are written with all ones. The tail rule takes precedence over the mask rule.
- R7: An active element (index < `vl`) with `mask_en` high and its `mask` bit low is masked off. With `mask_agn` low it produces no write. With `mask_agn` high its bytes are written with all ones. With `mask_en` low the mask has no effect.
- R8: When `vd` + (`nf_m1`+1) × group size exceeds 32, `cfg_illegal` is high and no beat produces a write. A layout ending exactly at register 31 is legal.
- R9: A beat whose field number is at or above the field count, or whose element index is at or beyond (16/width) × group size, produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vd | input | 5 | Destination base register |
| nf_m1 | input | 3 | Fields per segment minus one |
| eew_code | input | 2 | Element width code (8 << code bits) |
| emul_code | input | 2 | Register group size code (1 << code registers) |
| vl | input | 8 | Active element count, 0..128 |
| mask | input | 128 | Per-element mask bits, bit i for element i |
| mask_en | input | 1 | Apply the mask when high |
| tail_agn | input | 1 | Tail elements: 0 leave untouched, 1 fill with ones |
| mask_agn | input | 1 | Masked elements: 0 leave untouched, 1 fill with ones |
| in_valid | input | 1 | Beat present this cycle |
| in_elem | input | 7 | Element index of the beat |
| in_field | input | 3 | Field number of the beat |
| in_data | input | 64 | Element value, low bytes used |
| wr_valid | output | 1 | Register-file write this cycle |
| wr_reg | output | 5 | Register written |
| wr_be | output | 16 | Byte enables of the write |
| wr_data | output | 128 | Write data, aligned to its byte lanes |
| cfg_illegal | output | 1 | Layout runs past the last register |

## Verification
On every cycle, assertions check the following. An idle input, an illegal layout, an undisturbed tail element or an undisturbed masked element never leads to a write. Every write enables exactly as many bytes as the element width of the cycle before. No write lands below the base register. The exact register number, the lane position, the placement of the data bytes and the all-ones fill are checked only by the bench's reference model. The same holds for the field and group arithmetic across element widths and group sizes, and for the boundary between a legal layout and an illegal one. The model is compared with the outputs on every cycle of the directed scenarios.

// File: rtl/seg_deint_pkg.sv
package seg_deint_pkg;

   // Width and size code encodings shared by the block's sub-units
   typedef enum logic [1:0] {
      EW_B8  = 2'd0,
      EW_B16 = 2'd1,
      EW_B32 = 2'd2,
      EW_B64 = 2'd3
   } ew_code_e;

   // Number of registers covered by all fields of a segment layout
   function automatic int layout_span(input int fields_m1, input int grp_code);
      return (fields_m1 + 1) << grp_code;
   endfunction

   // First register of the group for a given field
   function automatic int field_group_base(input int base, input int fld, input int grp_code);
      return base + (fld << grp_code);
   endfunction

endpackage

// File: rtl/seg_deint_geom.sv
module seg_deint_geom
   import seg_deint_pkg::*;
#(
   parameter int NREG   = 32,
   parameter int MAX_NF = 8,
   localparam int RW    = $clog2(NREG),
   localparam int NFW   = $clog2(MAX_NF)
) (
   input  logic [RW-1:0]  vd,
   input  logic [NFW-1:0] nf_m1,
   input  logic [1:0]     emul_code,
   input  logic [NFW-1:0] field,
   output logic           illegal,
   output logic           field_ok,
   output logic [RW-1:0]  grp_base
);

   logic [RW-1:0] base_c [MAX_NF];

   // One candidate group base per possible field number
   for (genvar f = 0; f < MAX_NF; f++) begin : g_field
      assign base_c[f] = RW'(field_group_base(int'(vd), f, int'(emul_code)));
   end

   assign grp_base = base_c[field];
   assign field_ok = (field <= nf_m1);
   assign illegal  = (int'(vd) + layout_span(int'(nf_m1), int'(emul_code))) > NREG;

endmodule

// File: rtl/seg_deint_lane.sv
module seg_deint_lane
   import seg_deint_pkg::*;
#(
   parameter int VLEN     = 128,
   parameter int ELEN     = 64,
   parameter int MAX_EMUL = 8,
   localparam int VLENB   = VLEN / 8,
   localparam int ELENB   = ELEN / 8,
   localparam int N_EW    = $clog2(ELENB) + 1,
   localparam int IDXW    = $clog2(VLENB * MAX_EMUL),
   localparam int EMW     = $clog2(MAX_EMUL)
) (
   input  logic [IDXW-1:0]  elem,
   input  logic [1:0]       ew_code,
   input  logic [1:0]       emul_code,
   input  logic [ELEN-1:0]  data,
   output logic             in_group,
   output logic [EMW-1:0]   reg_off,
   output logic [VLENB-1:0] lane_be,
   output logic [VLEN-1:0]  lane_data
);

   logic [IDXW-1:0]  roff_c [N_EW];
   logic [VLENB-1:0] be_c   [N_EW];
   logic [VLEN-1:0]  dat_c  [N_EW];
   logic [IDXW-1:0]  roff;

   // One placement variant per supported element width
   for (genvar w = 0; w < N_EW; w++) begin : g_width
      localparam int EB = 1 << w;
      localparam int SH = $clog2(VLENB / EB);
      logic [SH-1:0] slot;
      assign slot      = elem[SH-1:0];
      assign roff_c[w] = elem >> SH;
      assign be_c[w]   = VLENB'({EB{1'b1}}) << (EB * int'(slot));
      assign dat_c[w]  = VLEN'(data[EB*8-1:0]) << (8 * EB * int'(slot));
   end

   always_comb begin
      roff      = '1;
      lane_be   = '0;
      lane_data = '0;
      if (int'(ew_code) < N_EW) begin
         roff      = roff_c[ew_code];
         lane_be   = be_c[ew_code];
         lane_data = dat_c[ew_code];
      end
   end

   assign in_group = roff < (IDXW'(1) << emul_code);
   assign reg_off  = roff[EMW-1:0];

endmodule

// File: rtl/seg_deint_policy.sv
module seg_deint_policy #(
   parameter int IDXW = 7,
   localparam int VLW = IDXW + 1
) (
   input  logic [IDXW-1:0] elem,
   input  logic [VLW-1:0]  vl,
   input  logic            mask_bit,
   input  logic            mask_en,
   input  logic            tail_agn,
   input  logic            mask_agn,
   output logic            write_en,
   output logic            fill_ones
);

   logic is_tail;
   logic is_off;

   assign is_tail = {1'b0, elem} >= vl;
   assign is_off  = mask_en && !mask_bit;

   // Tail decision first, then mask, then an ordinary active element
   always_comb begin
      if (is_tail) begin
         write_en  = tail_agn;
         fill_ones = 1'b1;
      end else if (is_off) begin
         write_en  = mask_agn;
         fill_ones = 1'b1;
      end else begin
         write_en  = 1'b1;
         fill_ones = 1'b0;
      end
   end

endmodule

// File: rtl/seg_deint.sv
module seg_deint #(
   parameter int VLEN     = 128,
   parameter int ELEN     = 64,
   parameter int NREG     = 32,
   parameter int MAX_NF   = 8,
   parameter int MAX_EMUL = 8,
   localparam int VLENB   = VLEN / 8,
   localparam int MAXVL   = VLENB * MAX_EMUL,
   localparam int IDXW    = $clog2(MAXVL),
   localparam int VLW     = IDXW + 1,
   localparam int RW      = $clog2(NREG),
   localparam int NFW     = $clog2(MAX_NF),
   localparam int EMW     = $clog2(MAX_EMUL)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [RW-1:0]    vd,
   input  logic [NFW-1:0]   nf_m1,
   input  logic [1:0]       eew_code,
   input  logic [1:0]       emul_code,
   input  logic [VLW-1:0]   vl,
   input  logic [MAXVL-1:0] mask,
   input  logic             mask_en,
   input  logic             tail_agn,
   input  logic             mask_agn,
   input  logic             in_valid,
   input  logic [IDXW-1:0]  in_elem,
   input  logic [NFW-1:0]   in_field,
   input  logic [ELEN-1:0]  in_data,
   output logic             wr_valid,
   output logic [RW-1:0]    wr_reg,
   output logic [VLENB-1:0] wr_be,
   output logic [VLEN-1:0]  wr_data,
   output logic             cfg_illegal
);

   // Elaboration-time parameter checks
   if (VLEN < 2 * ELEN || (VLEN & (VLEN - 1)) != 0) begin : g_chk_vlen
      $error("seg_deint: VLEN must be a power of two and at least twice ELEN");
   end
   if (ELEN < 8 || ELEN > 64 || (ELEN & (ELEN - 1)) != 0) begin : g_chk_elen
      $error("seg_deint: ELEN must be a power of two between 8 and 64");
   end
   if ((NREG & (NREG - 1)) != 0 || NREG < MAX_EMUL) begin : g_chk_nreg
      $error("seg_deint: NREG must be a power of two no smaller than MAX_EMUL");
   end
   if (MAX_EMUL != 8 || (MAX_NF & (MAX_NF - 1)) != 0 || MAX_NF < 2) begin : g_chk_grp
      $error("seg_deint: group size code is two bits; MAX_NF must be a power of two");
   end

   logic             illegal;
   logic             field_ok;
   logic [RW-1:0]    grp_base;
   logic             in_group;
   logic [EMW-1:0]   reg_off;
   logic [VLENB-1:0] lane_be;
   logic [VLEN-1:0]  lane_data;
   logic [VLEN-1:0]  ones_data;
   logic             pol_write;
   logic             pol_ones;
   logic             do_write;

   seg_deint_geom #(
      .NREG   (NREG),
      .MAX_NF (MAX_NF)
   ) geom_i (
      .vd        (vd),
      .nf_m1     (nf_m1),
      .emul_code (emul_code),
      .field     (in_field),
      .illegal   (illegal),
      .field_ok  (field_ok),
      .grp_base  (grp_base)
   );

   seg_deint_lane #(
      .VLEN     (VLEN),
      .ELEN     (ELEN),
      .MAX_EMUL (MAX_EMUL)
   ) lane_i (
      .elem      (in_elem),
      .ew_code   (eew_code),
      .emul_code (emul_code),
      .data      (in_data),
      .in_group  (in_group),
      .reg_off   (reg_off),
      .lane_be   (lane_be),
      .lane_data (lane_data)
   );

   seg_deint_policy #(
      .IDXW (IDXW)
   ) policy_i (
      .elem      (in_elem),
      .vl        (vl),
      .mask_bit  (mask[in_elem]),
      .mask_en   (mask_en),
      .tail_agn  (tail_agn),
      .mask_agn  (mask_agn),
      .write_en  (pol_write),
      .fill_ones (pol_ones)
   );

   // Byte-wise all-ones pattern over the enabled lanes
   for (genvar b = 0; b < VLENB; b++) begin : g_fill
      assign ones_data[b*8 +: 8] = {8{lane_be[b]}};
   end

   assign cfg_illegal = illegal;
   assign do_write    = in_valid && !illegal && field_ok && in_group && pol_write;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_valid <= 1'b0;
         wr_reg   <= '0;
         wr_be    <= '0;
         wr_data  <= '0;
      end else begin
         wr_valid <= do_write;
         wr_be    <= do_write ? lane_be : '0;
         if (do_write) begin
            wr_reg  <= grp_base + RW'(reg_off);
            wr_data <= pol_ones ? ones_data : lane_data;
         end
      end
   end

   // Assertions
   a_r2_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !wr_valid);

   a_r8_illegal_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && cfg_illegal |=> !wr_valid);

   a_r6_tail_undisturbed: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && ({1'b0, in_elem} >= vl) && !tail_agn |=> !wr_valid);

   a_r7_mask_undisturbed: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && mask_en && !mask[in_elem] && ({1'b0, in_elem} < vl) && !mask_agn
      |=> !wr_valid);

   a_r4_be_width: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> $countones(wr_be) == (1 << $past(eew_code)));

   a_r3_reg_not_below_base: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> wr_reg >= $past(vd));

endmodule

// File: tb/seg_deint_tb.sv
module seg_deint_tb_top;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [4:0]   vd;
   logic [2:0]   nf_m1;
   logic [1:0]   eew_code;
   logic [1:0]   emul_code;
   logic [7:0]   vl;
   logic [127:0] mask;
   logic         mask_en, tail_agn, mask_agn;
   logic         in_valid;
   logic [6:0]   in_elem;
   logic [2:0]   in_field;
   logic [63:0]  in_data;
   logic         wr_valid;
   logic [4:0]   wr_reg;
   logic [15:0]  wr_be;
   logic [127:0] wr_data;
   logic         cfg_illegal;

   always #2 clk = ~clk;

   seg_deint dut_i (
      .clk(clk), .rst_n(rst_n), .vd(vd), .nf_m1(nf_m1), .eew_code(eew_code),
      .emul_code(emul_code), .vl(vl), .mask(mask), .mask_en(mask_en),
      .tail_agn(tail_agn), .mask_agn(mask_agn), .in_valid(in_valid),
      .in_elem(in_elem), .in_field(in_field), .in_data(in_data),
      .wr_valid(wr_valid), .wr_reg(wr_reg), .wr_be(wr_be), .wr_data(wr_data),
      .cfg_illegal(cfg_illegal)
   );

   int     n_vec = 0;
   int     n_bad = 0;
   bit     done  = 0;
   string  req   = "R1";
   logic         exp_v;
   logic [4:0]   exp_reg;
   logic [15:0]  exp_be;
   logic [127:0] exp_data;

   task automatic fail3(input string what, input logic [127:0] got, input logic [127:0] exp);
      n_bad++;
      $display("FAIL %s %s got %0h expected %0h", req, what, got, exp);
   endtask

   // Compare outputs with the model's prediction for the previous beat
   task automatic compare();
      n_vec++;
      if (wr_valid !== exp_v) fail3("wr_valid", 128'(wr_valid), 128'(exp_v));
      if (exp_v) begin
         n_vec += 3;
         if (wr_reg !== exp_reg)   fail3("wr_reg", 128'(wr_reg), 128'(exp_reg));
         if (wr_be !== exp_be)     fail3("wr_be", 128'(wr_be), 128'(exp_be));
         if (wr_data !== exp_data) fail3("wr_data", wr_data, exp_data);
      end else begin
         n_vec++;
         if (wr_be !== 16'h0) fail3("wr_be idle", 128'(wr_be), 128'h0);
      end
   endtask

   // Behavioural model of one beat
   task automatic model(input int e, input int f, input logic [63:0] d);
      int  ew, epr, em, nf, lane;
      bit  ones;
      ew = 1 << eew_code; epr = 16 / ew; em = 1 << emul_code; nf = nf_m1 + 1;
      exp_v = 0; exp_be = '0; exp_data = '0; exp_reg = '0;
      if (vd + nf * em > 32) return;
      if (f >= nf) return;
      if (e >= epr * em) return;
      if (e >= vl) begin
         if (!tail_agn) return;
         ones = 1;
      end else if (mask_en && !mask[e]) begin
         if (!mask_agn) return;
         ones = 1;
      end else ones = 0;
      exp_v   = 1;
      exp_reg = 5'(vd + f * em + e / epr);
      lane    = (e % epr) * ew;
      for (int b = 0; b < ew; b++) begin
         exp_be[lane + b] = 1'b1;
         exp_data[(lane + b) * 8 +: 8] = ones ? 8'hFF : d[b * 8 +: 8];
      end
   endtask

   function automatic logic [63:0] pat(input int e, input int f);
      return 64'h1122_3344_5566_7788 + 64'(e) * 64'h0000_0103_0001_0005 + 64'(f) * 64'h0700_0000_0090_0000;
   endfunction

   task automatic beat(input int e, input int f);
      @(negedge clk);
      compare();
      in_valid = 1'b1; in_elem = 7'(e); in_field = 3'(f); in_data = pat(e, f);
      model(e, f, in_data);
   endtask

   task automatic idle();
      @(negedge clk);
      compare();
      in_valid = 1'b0;
      exp_v = 0;
   endtask

   task automatic cfg(input int b, input int nfm1, input int ewc, input int emc, input int l);
      idle();
      vd = 5'(b); nf_m1 = 3'(nfm1); eew_code = 2'(ewc); emul_code = 2'(emc); vl = 8'(l);
   endtask

   task automatic check_illegal(input logic exp);
      #1;
      n_vec++;
      if (cfg_illegal !== exp) fail3("cfg_illegal", 128'(cfg_illegal), 128'(exp));
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R2 watchdog expired got hang expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_elem = '0; in_field = '0; in_data = '0;
      vd = '0; nf_m1 = '0; eew_code = '0; emul_code = '0; vl = '0; mask = '0;
      mask_en = 0; tail_agn = 0; mask_agn = 0;
      exp_v = 0; exp_reg = '0; exp_be = '0; exp_data = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      n_vec += 4;
      if (wr_valid !== 1'b0) fail3("wr_valid", 128'(wr_valid), 128'h0);
      if (wr_reg !== 5'h0)   fail3("wr_reg", 128'(wr_reg), 128'h0);
      if (wr_be !== 16'h0)   fail3("wr_be", 128'(wr_be), 128'h0);
      if (wr_data !== '0)    fail3("wr_data", wr_data, 128'h0);
      rst_n = 1'b1;

      // R3: three fields, group of two, base v4, 32-bit elements
      req = "R3";
      cfg(4, 2, 2, 1, 8);
      for (int f = 0; f < 3; f++)
         for (int e = 0; e < 8; e++) beat(e, f);

      // R4: other element widths and group sizes
      req = "R4";
      cfg(8, 0, 0, 3, 128);
      beat(0, 0); beat(15, 0); beat(16, 0); beat(100, 0); beat(127, 0);
      cfg(31, 0, 1, 0, 8);
      for (int e = 0; e < 8; e++) beat(e, 0);
      cfg(0, 1, 3, 2, 8);
      for (int e = 0; e < 8; e++) begin beat(e, 0); beat(e, 1); end

      // R5: same element index, mask and length rule in every field group
      req = "R5";
      cfg(0, 3, 1, 1, 6);
      mask = {8{16'h5AA5}}; mask_en = 1;
      for (int e = 0; e < 8; e++)
         for (int f = 0; f < 4; f++) beat(e, f);
      mask_en = 0;

      // R6: tail elements under both policies, and an empty active length
      req = "R6";
      cfg(2, 0, 0, 0, 5);
      tail_agn = 0;
      for (int e = 3; e < 10; e++) beat(e, 0);
      idle(); tail_agn = 1;
      for (int e = 3; e < 10; e++) beat(e, 0);
      cfg(2, 0, 0, 0, 0);
      for (int e = 0; e < 4; e++) beat(e, 0);
      idle(); tail_agn = 0;

      // R7: masked elements under both policies, mask disabled, tail precedence
      req = "R7";
      cfg(10, 0, 0, 0, 16);
      mask = {64{2'b10}}; mask_en = 1; mask_agn = 0;
      for (int e = 0; e < 8; e++) beat(e, 0);
      idle(); mask_agn = 1;
      for (int e = 0; e < 8; e++) beat(e, 0);
      idle(); mask_en = 0;
      for (int e = 0; e < 8; e++) beat(e, 0);
      cfg(10, 0, 0, 0, 4);
      mask_en = 1; mask_agn = 0; tail_agn = 1;
      beat(6, 0); beat(2, 0);
      idle(); mask_en = 0; tail_agn = 0; mask_agn = 0;

      // R8: layouts at and past the last register
      req = "R8";
      cfg(26, 2, 2, 1, 8);
      check_illegal(1'b0);
      beat(7, 2); beat(0, 0);
      cfg(28, 2, 2, 1, 8);
      check_illegal(1'b1);
      beat(0, 0); beat(3, 1);
      cfg(31, 1, 0, 0, 16);
      check_illegal(1'b1);
      beat(0, 0);
      cfg(24, 0, 0, 3, 128);
      check_illegal(1'b0);
      beat(127, 0);

      // R9: field number and element index out of range
      req = "R9";
      cfg(0, 1, 2, 0, 128);
      for (int f = 2; f < 8; f++) beat(0, f);
      beat(4, 0); beat(3, 1); beat(100, 0);

      // R2: idle cycles between beats
      req = "R2";
      cfg(5, 0, 1, 1, 16);
      beat(1, 0); idle(); idle(); beat(9, 0); idle(); beat(15, 0); beat(2, 0);
      idle(); idle();

      done = 1;
      summary();
      $finish;
   end

endmodule